// File: doc/BRIEF.md
# Four-Channel DMA Transfer Controller

This block moves data directly between I/O devices and memory on four independent channels, so that the processor does not have to copy each word itself. Each channel holds a current address, a transfer count and a mode. A channel becomes ready when its device request line rises or when software sets its bit in the request register. The controller then asks for the system bus with `hold`, waits for `hlda`, and performs one transfer per clock. During each transfer it drives the address, the memory and I/O strobes and the channel's acknowledge. After every transfer it advances the address and lowers the count.

A channel finishes its service on one of several events: terminal count, the external end-of-process input, the end of a single transfer in single mode, or a dropped device request in demand mode. At terminal count the channel either reloads its programmed start values (auto-initialize) or masks itself. A per-channel terminal-count flag is kept in a status register, which clears when it is read.

The processor programs the block through a small register port. Writes take effect at the clock edge. Reads are combinational.

Top module: `dmac_top`

## Requirements
- R1: After reset `hold`, every strobe and every `dack` bit are low, all four channels are masked (mask register at address 0xA reads 0xF), and the status register at address 0xB reads 0.
- R2: An unmasked pending channel raises `hold`. No strobe or `dack` is asserted while `hlda` is low. `hold` falls once the service has ended.
- R3: When several unmasked channels are pending while the controller is idle, the lowest-numbered channel is served first.
- R4: The per-channel registers sit at addresses 2n (address) and 2n+1 (count) for channel n. Writing one of them loads both the current and the base value, and reading it returns the current value. After each transfer the count drops by one, and the address rises by one, or falls by one when mode bit 3 (decrement) is set.
- R5: The mode register sits at address 0x8. Bits [1:0] select the channel, bit 2 sets direction, bit 3 sets decrement, bit 4 sets auto-initialize, and bits [6:5] set the transfer mode: 0 single, 1 block, 2 demand. With bit 2 set, a transfer asserts `io_rd` and `mem_wr`. With bit 2 clear, it asserts `mem_rd` and `io_wr`. The strobes are active high.
- R6: A transfer made while the count is 0 is the terminal-count transfer. It pulses `tc_out`, wraps the count to 0xFFFF when auto-initialize is off, ends the service, and sets that channel's bit in status bits [3:0].
- R7: At terminal count, a channel without auto-initialize sets its mask bit. A channel with auto-initialize reloads its address and count from the base values and stays unmasked.
- R8: In single mode a channel makes exactly one transfer per service, and `hold` drops in the following cycle.
- R9: In block mode transfers continue on consecutive cycles under one `hold` until terminal count or end-of-process.
- R10: In demand mode the service also ends after the transfer during which that channel's `dreq` is low.
- R11: When `eop_in` is high during a transfer, that transfer is the last of the service. The mask bit and the status flag are left unchanged, and the count keeps its decremented value.
- R12: The software request register is at address 0x9 and is written as a 4-bit field. A channel's bit clears when its service ends. Reading status returns the terminal-count flags in [3:0] and the live requests (`dreq` OR software request) in [7:4]. The read clears the flags.
- R13: A masked channel is never served, whether the request comes from `dreq` or from software. The mask register is at address 0xA and is written as a 4-bit field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | Register write strobe |
| cpu_rd_en | input | 1 | Register read strobe (clears status on read) |
| cpu_addr | input | 4 | Register address |
| cpu_wdata | input | AW | Register write data |
| cpu_rdata | output | AW | Register read data |
| dreq | input | NCH | Device request lines |
| eop_in | input | 1 | External end-of-process |
| hlda | input | 1 | Bus grant from the processor |
| hold | output | 1 | Bus request to the processor |
| dack | output | NCH | Per-channel transfer acknowledge |
| bus_addr | output | AW | Memory address during a transfer |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| tc_out | output | 1 | Terminal-count pulse |

## Verification
Assertions check on every cycle that strobes appear only while the bus is granted. They also check that `dack` is one-hot or idle, that single mode releases `hold` right after its transfer, and that channel 0 wins when it is pending at an idle decision. They cover the per-transfer address step, the count wrap or reload at terminal count, and the self-mask at terminal count. The end-to-end behaviour needs the bench's scenarios: the exact sequence of addresses and directions per channel, the number of bus requests per service, demand and end-of-process cut-offs at precise cycles, clear-on-read status, and a re-run after auto-initialize.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {
    XM_SINGLE = 2'd0,
    XM_BLOCK  = 2'd1,
    XM_DEMAND = 2'd2
  } xmode_e;

  // field order matches write-data bits [6:2] of the mode register
  typedef struct packed {
    xmode_e xm;
    logic   autoinit;
    logic   dec;
    logic   dev2mem;
  } chmode_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2
  } st_e;
endpackage

// File: rtl/dmac_prio.sv
module dmac_prio #(
  parameter int NCH = 4,
  parameter int CHW = 2
) (
  input  logic [NCH-1:0] req,
  output logic           any,
  output logic [CHW-1:0] idx
);
  // fixed priority: lowest index wins
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) idx = CHW'(i);
    end
  end
endmodule

// File: rtl/dmac_channel.sv
module dmac_channel #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_addr,
  input  logic          ld_cnt,
  input  logic [AW-1:0] wdata,
  input  logic          step,
  input  logic          dec,
  input  logic          autoinit,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] cur_cnt,
  output logic          at_tc
);
  logic [AW-1:0] base_addr_q, base_addr_d, base_cnt_q, base_cnt_d;
  logic [AW-1:0] addr_q, addr_d, cnt_q, cnt_d;

  assign at_tc    = (cnt_q == '0);
  assign cur_addr = addr_q;
  assign cur_cnt  = cnt_q;

  always_comb begin
    base_addr_d = base_addr_q;
    base_cnt_d  = base_cnt_q;
    addr_d      = addr_q;
    cnt_d       = cnt_q;
    if (step) begin
      if (at_tc && autoinit) begin
        addr_d = base_addr_q;
        cnt_d  = base_cnt_q;
      end else begin
        addr_d = dec ? addr_q - AW'(1) : addr_q + AW'(1);
        cnt_d  = cnt_q - AW'(1);
      end
    end
    if (ld_addr) begin
      base_addr_d = wdata;
      addr_d      = wdata;
    end
    if (ld_cnt) begin
      base_cnt_d = wdata;
      cnt_d      = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      addr_q      <= '0;
      cnt_q       <= '0;
    end else begin
      base_addr_q <= base_addr_d;
      base_cnt_q  <= base_cnt_d;
      addr_q      <= addr_d;
      cnt_q       <= cnt_d;
    end
  end

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !(at_tc && autoinit) && !ld_addr) |=>
      (cur_addr == ($past(dec) ? $past(cur_addr) - AW'(1) : $past(cur_addr) + AW'(1))));

  // R6
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_tc && !autoinit && !ld_cnt) |=> (&cur_cnt));

  // R7
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_tc && autoinit && !ld_cnt && !ld_addr) |=>
      (cur_cnt == $past(base_cnt_q) && cur_addr == $past(base_addr_q)));
endmodule

// File: rtl/dmac_top.sv
module dmac_top
  import dmac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpu_wr_en,
  input  logic           cpu_rd_en,
  input  logic [3:0]     cpu_addr,
  input  logic [AW-1:0]  cpu_wdata,
  output logic [AW-1:0]  cpu_rdata,
  input  logic [NCH-1:0] dreq,
  input  logic           eop_in,
  input  logic           hlda,
  output logic           hold,
  output logic [NCH-1:0] dack,
  output logic [AW-1:0]  bus_addr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           io_rd,
  output logic           io_wr,
  output logic           tc_out
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [3:0] A_MODE  = 4'h8;
  localparam logic [3:0] A_SWREQ = 4'h9;
  localparam logic [3:0] A_MASK  = 4'hA;
  localparam logic [3:0] A_STAT  = 4'hB;

  st_e                   state_q, state_d;
  logic [CHW-1:0]        gch_q, gch_d, arb_idx;
  logic [NCH-1:0]        mask_q, mask_d, swreq_q, swreq_d, tcflag_q, tcflag_d;
  logic [NCH-1:0]        pend, ch_tc, step, ld_a, ld_c;
  chmode_t [NCH-1:0]     mode_q, mode_d;
  logic [AW-1:0]         caddr [NCH];
  logic [AW-1:0]         ccnt  [NCH];
  chmode_t               gm;
  logic                  arb_any, xfer, last, cur_tc;

  assign pend   = (dreq | swreq_q) & ~mask_q;
  assign gm     = mode_q[gch_q];
  assign xfer   = (state_q == ST_XFER);
  assign cur_tc = ch_tc[gch_q];
  assign last   = cur_tc | eop_in | (gm.xm == XM_SINGLE)
                | ((gm.xm == XM_DEMAND) & ~dreq[gch_q]);

  dmac_prio #(.NCH(NCH), .CHW(CHW)) u_prio (
    .req (pend),
    .any (arb_any),
    .idx (arb_idx)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ld_a[i] = cpu_wr_en && !cpu_addr[3] && (cpu_addr[CHW:1] == CHW'(i)) && !cpu_addr[0];
    assign ld_c[i] = cpu_wr_en && !cpu_addr[3] && (cpu_addr[CHW:1] == CHW'(i)) &&  cpu_addr[0];
    assign step[i] = xfer && (gch_q == CHW'(i));
    dmac_channel #(.AW(AW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_addr  (ld_a[i]),
      .ld_cnt   (ld_c[i]),
      .wdata    (cpu_wdata),
      .step     (step[i]),
      .dec      (mode_q[i].dec),
      .autoinit (mode_q[i].autoinit),
      .cur_addr (caddr[i]),
      .cur_cnt  (ccnt[i]),
      .at_tc    (ch_tc[i])
    );
  end

  // sequencer next state
  always_comb begin
    state_d = state_q;
    gch_d   = gch_q;
    case (state_q)
      ST_IDLE: if (arb_any) begin
        gch_d   = arb_idx;
        state_d = ST_WAIT;
      end
      ST_WAIT: if (hlda) state_d = ST_XFER;
      ST_XFER: if (last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // register file next state; service updates follow software writes
  always_comb begin
    mask_d   = mask_q;
    swreq_d  = swreq_q;
    tcflag_d = tcflag_q;
    mode_d   = mode_q;
    if (cpu_rd_en && cpu_addr == A_STAT) tcflag_d = '0;
    if (cpu_wr_en) begin
      case (cpu_addr)
        A_MODE:  mode_d[cpu_wdata[CHW-1:0]] = chmode_t'(cpu_wdata[6:2]);
        A_SWREQ: swreq_d = cpu_wdata[NCH-1:0];
        A_MASK:  mask_d  = cpu_wdata[NCH-1:0];
        default: ;
      endcase
    end
    if (xfer) begin
      if (last) swreq_d[gch_q] = 1'b0;
      if (cur_tc) begin
        tcflag_d[gch_q] = 1'b1;
        if (!gm.autoinit) mask_d[gch_q] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      gch_q    <= '0;
      mask_q   <= '1;
      swreq_q  <= '0;
      tcflag_q <= '0;
      mode_q   <= '0;
    end else begin
      state_q  <= state_d;
      gch_q    <= gch_d;
      mask_q   <= mask_d;
      swreq_q  <= swreq_d;
      tcflag_q <= tcflag_d;
      mode_q   <= mode_d;
    end
  end

  // read path
  always_comb begin
    cpu_rdata = '0;
    if (!cpu_addr[3]) begin
      cpu_rdata = cpu_addr[0] ? ccnt[cpu_addr[CHW:1]] : caddr[cpu_addr[CHW:1]];
    end else if (cpu_addr == A_MASK) begin
      cpu_rdata[NCH-1:0] = mask_q;
    end else if (cpu_addr == A_STAT) begin
      cpu_rdata[NCH-1:0]     = tcflag_q;
      cpu_rdata[2*NCH-1:NCH] = dreq | swreq_q;
    end
  end

  // bus side
  assign hold     = (state_q != ST_IDLE);
  assign dack     = xfer ? (NCH'(1) << gch_q) : '0;
  assign bus_addr = xfer ? caddr[gch_q] : '0;
  assign mem_rd   = xfer & ~gm.dev2mem;
  assign io_wr    = xfer & ~gm.dev2mem;
  assign io_rd    = xfer &  gm.dev2mem;
  assign mem_wr   = xfer &  gm.dev2mem;
  assign tc_out   = xfer & cur_tc;

  // R2
  strobe_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd | mem_wr | io_rd | io_wr | (|dack)) |-> (hlda && hold));

  // R5
  dack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack) && !(mem_rd && mem_wr) && !(io_rd && io_wr));

  // R8
  single_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && gm.xm == XM_SINGLE) |=> !hold);

  // R7
  mask_on_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && cur_tc && !gm.autoinit) |=> mask_q[$past(gch_q)]);

  // R3
  prio_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && pend[0]) |=> (gch_q == '0));
endmodule

// File: tb/tb_dmac_top.sv
module tb_dmac_top;
  localparam int NCH = 4;
  localparam int AW  = 16;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           cpu_wr_en, cpu_rd_en;
  logic [3:0]     cpu_addr;
  logic [AW-1:0]  cpu_wdata, cpu_rdata;
  logic [NCH-1:0] dreq;
  logic           eop_in, hlda, hlda_en;
  logic           hold, mem_rd, mem_wr, io_rd, io_wr, tc_out;
  logic [NCH-1:0] dack;
  logic [AW-1:0]  bus_addr;

  typedef struct {
    int            ch;
    logic [AW-1:0] a;
    logic          d2m;
  } xp_t;
  xp_t q[$];

  int checks = 0, errors = 0;
  int mon_checks = 0, mon_errors = 0;
  int hold_rises = 0, tc_pulses = 0, cyc = 0;
  logic prev_hold = 1'b0;

  always #5 clk = ~clk;

  dmac_top #(.NCH(NCH), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_rd_en(cpu_rd_en),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .dreq(dreq), .eop_in(eop_in), .hlda(hlda), .hold(hold), .dack(dack),
    .bus_addr(bus_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
    .io_wr(io_wr), .tc_out(tc_out)
  );

  // processor model: grants the bus one cycle after the request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hlda <= 1'b0;
    else        hlda <= hlda_en & hold;
  end

  // monitor: pops expected transfers and compares
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold && !prev_hold) hold_rises++;
      prev_hold = hold;
      if (tc_out) tc_pulses++;
      if (dack != '0) begin
        int ch;
        logic [3:0] strobes, exp_s;
        ch = 0;
        for (int i = 0; i < NCH; i++) if (dack[i]) ch = i;
        strobes = {mem_rd, mem_wr, io_rd, io_wr};
        mon_checks++;
        if (q.size() == 0) begin
          mon_errors++;
          $display("FAIL R9 unexpected transfer ch%0d addr %h (expected none)", ch, bus_addr);
        end else begin
          xp_t e;
          e = q.pop_front();
          exp_s = e.d2m ? 4'b0110 : 4'b1001;
          if (ch != e.ch || bus_addr !== e.a || strobes !== exp_s) begin
            mon_errors++;
            $display("FAIL R4/R5 transfer got ch%0d addr %h strobes %b, expected ch%0d addr %h strobes %b",
                     ch, bus_addr, strobes, e.ch, e.a, exp_s);
          end
        end
      end
    end
  end

  // watchdog
  always @(negedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      $display("FAIL watchdog expired (actual hung, expected completion)");
      $display("Simulation finished: %0d checks, %0d errors",
               checks + mon_checks + 1, errors + mon_errors + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [AW-1:0] d);
    @(negedge clk);
    cpu_wr_en = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [AW-1:0] d);
    @(negedge clk);
    cpu_rd_en = 1'b1; cpu_addr = a;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_rd_en = 1'b0;
  endtask

  task automatic push(input int ch, input logic [AW-1:0] a, input logic d2m);
    xp_t e;
    e.ch = ch; e.a = a; e.d2m = d2m;
    q.push_back(e);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
    while (q.size() != 0 || hold) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [AW-1:0] v;
    int base;
    rst_n = 1'b0; cpu_wr_en = 1'b0; cpu_rd_en = 1'b0; cpu_addr = '0;
    cpu_wdata = '0; dreq = '0; eop_in = 1'b0; hlda_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(hold == 1'b0 && dack == '0 && !mem_rd && !mem_wr && !io_rd && !io_wr,
          "R1 idle outputs", {hold, dack}, 0);
    rd(4'hA, v); check(v == 16'h000F, "R1 mask reset", v, 16'h000F);
    rd(4'hB, v); check(v == 16'h0000, "R1 status reset", v, 0);

    // R13 + R9: ch1 block, increment, mem->dev, 3 transfers
    wr(4'h8, 16'h0021);
    wr(4'h2, 16'h0100);
    wr(4'h3, 16'h0002);
    wr(4'h9, 16'h0002);
    repeat (6) @(negedge clk);
    check(hold == 1'b0, "R13 masked sw request ignored", hold, 0);
    push(1, 16'h0100, 0); push(1, 16'h0101, 0); push(1, 16'h0102, 0);
    base = hold_rises;
    wr(4'hA, 16'h0000);
    drain();
    check(hold_rises - base == 1, "R9 one bus request for block", hold_rises - base, 1);
    check(tc_pulses == 1, "R6 tc pulse", tc_pulses, 1);
    rd(4'h2, v); check(v == 16'h0103, "R4 address advanced", v, 16'h0103);
    rd(4'h3, v); check(v == 16'hFFFF, "R6 count wrap", v, 16'hFFFF);
    rd(4'hB, v); check(v == 16'h0002, "R12 status tc flag ch1", v, 16'h0002);
    rd(4'hB, v); check(v == 16'h0000, "R12 status cleared on read", v, 0);
    rd(4'hA, v); check(v == 16'h0002, "R7 ch1 masked at tc", v, 16'h0002);

    // R8 + R5 + R4: ch2 single, decrement, dev->mem, dreq held
    wr(4'h8, 16'h000E);
    wr(4'h4, 16'h0050);
    wr(4'h5, 16'h0001);
    push(2, 16'h0050, 1); push(2, 16'h004F, 1);
    base = hold_rises;
    @(negedge clk); dreq[2] = 1'b1;
    drain();
    rd(4'hB, v); check(v == 16'h0044, "R12 live request and tc ch2", v, 16'h0044);
    dreq[2] = 1'b0;
    check(hold_rises - base == 2, "R8 one request per single transfer", hold_rises - base, 2);
    rd(4'hA, v); check(v == 16'h0006, "R7 ch2 masked at tc", v, 16'h0006);

    // R10: ch3 demand, dreq dropped during second transfer
    wr(4'h8, 16'h0043);
    wr(4'h6, 16'h0200);
    wr(4'h7, 16'h0005);
    wr(4'hA, 16'h0000);
    push(3, 16'h0200, 0); push(3, 16'h0201, 0);
    @(negedge clk); dreq[3] = 1'b1;
    do @(negedge clk); while (!dack[3]);
    @(negedge clk); dreq[3] = 1'b0;
    drain();
    rd(4'h7, v); check(v == 16'h0003, "R10 demand stopped on dreq low", v, 3);

    // R7: ch0 block with auto-initialize, run twice
    wr(4'h8, 16'h0030);
    wr(4'h0, 16'h0300);
    wr(4'h1, 16'h0001);
    push(0, 16'h0300, 0); push(0, 16'h0301, 0);
    wr(4'h9, 16'h0001);
    drain();
    rd(4'h0, v); check(v == 16'h0300, "R7 address reloaded", v, 16'h0300);
    rd(4'h1, v); check(v == 16'h0001, "R7 count reloaded", v, 1);
    rd(4'hA, v); check(v == 16'h0000, "R7 autoinit stays unmasked", v, 0);
    rd(4'hB, v); check(v == 16'h0001, "R6 tc flag ch0", v, 1);
    push(0, 16'h0300, 0); push(0, 16'h0301, 0);
    wr(4'h9, 16'h0001);
    drain();

    // R3: ch0 and ch1 requested together
    wr(4'h8, 16'h0000);
    wr(4'h0, 16'h0010); wr(4'h1, 16'h0005);
    wr(4'h8, 16'h0001);
    wr(4'h2, 16'h0020); wr(4'h3, 16'h0005);
    push(0, 16'h0010, 0); push(1, 16'h0020, 0);
    wr(4'h9, 16'h0003);
    drain();
    check(q.size() == 0, "R3 both channels served", q.size(), 0);

    // R11: ch2 block stopped by eop during second transfer
    rd(4'hB, v);
    wr(4'h8, 16'h0022);
    wr(4'h4, 16'h0400); wr(4'h5, 16'h000A);
    push(2, 16'h0400, 0); push(2, 16'h0401, 0);
    wr(4'h9, 16'h0004);
    do @(negedge clk); while (!dack[2]);
    @(negedge clk); eop_in = 1'b1;
    @(negedge clk); eop_in = 1'b0;
    drain();
    rd(4'h5, v); check(v == 16'h0008, "R11 count after eop", v, 8);
    rd(4'hA, v); check(v == 16'h0000, "R11 no mask on eop", v, 0);
    rd(4'hB, v); check(v == 16'h0000, "R11 no tc flag on eop", v, 0);

    // R2: grant withheld
    hlda_en = 1'b0;
    wr(4'h2, 16'h0030); wr(4'h3, 16'h0003);
    wr(4'h9, 16'h0002);
    repeat (8) @(negedge clk);
    check(hold == 1'b1, "R2 hold raised while waiting", hold, 1);
    check(dack == '0, "R2 no transfer without hlda", dack, 0);
    push(1, 16'h0030, 0);
    hlda_en = 1'b1;
    drain();
    check(hold == 1'b0, "R2 hold dropped after service", hold, 0);

    $display("Simulation finished: %0d checks, %0d errors",
             checks + mon_checks, errors + mon_errors);
    $finish;
  end
endmodule